// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. A host starts a conversion by pulling an active-low select strobe and an active-low write strobe low together. The block then walks a trial code from the most significant bit down to the least significant one. It presents each trial to an external resistor-ladder DAC and reads back a single comparator bit. When the last bit is settled it copies the code into an output latch and pulls an active-low interrupt low.

A start flip-flop holds the whole sequencer cleared for as long as both strobes are low. After either strobe returns high, it lets go only on the last clock of a free-running 8-clock time base. The start of the conversion therefore lands 1 to 8 clocks after the strobe edge. A new start during a conversion aborts it. Feeding the interrupt back into the write strobe, with select tied low, gives free-running conversions once a single write pulse has started the loop.

The analog ladder and comparator sit outside. The comparator bit is high when the analog input lies below the current trial level.

Top module: `sarctl_top`

## Requirements
- R1: After reset, irq_n is 1, trial_code is 0x00 and result is 0x00, and they stay so while no start is given.
- R2: A clock edge that samples cs_n = 0 and wr_n = 0 together makes trial_code 0x00 and irq_n 1 from that edge on, and both stay so for as long as both strobes stay low.
- R3: A strobe with cs_n = 1 has no effect: irq_n, trial_code and result keep their values while wr_n is low.
- R4: Once a strobe is released, trial_code becomes 0x80 between 1 and 8 clocks later, set by the phase of a free-running 8-clock time base; eight releases at eight consecutive phases give each delay 1 to 8 exactly once.
- R5: Bits are tried MSB first, each held for 8 clocks. During the slot of bit b, trial_code is the bits already decided above b, with bit b set to 1 and the bits below it 0. At the slot's last clock, bit b is cleared if cmp_lo = 1.
- R6: irq_n falls exactly 64 clocks after trial_code first shows 0x80, and stays high throughout those 64 clocks.
- R7: With an ideal comparator (cmp_lo = input < trial_code), result equals the 8-bit input code for all 256 codes, 0xFF being full scale.
- R8: result keeps the previous conversion's value during a conversion, and irq_n stays low after a conversion until the next start condition.
- R9: A start condition during a conversion aborts it and restarts from the MSB; result keeps the old value until the restarted conversion completes.
- R10: With wr_n driven by irq_n and cs_n = 0, nothing starts until one write pulse is given. After that pulse, conversions repeat every 72 clocks, with irq_n low for one clock each time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select strobe |
| wr_n | input | 1 | Active-low write (start) strobe |
| cmp_lo | input | 1 | Comparator: 1 when the analog input is below the trial level |
| trial_code | output | 8 | Trial code to the external ladder DAC |
| result | output | 8 | Latched result of the last completed conversion |
| irq_n | output | 1 | Active-low conversion-done interrupt |

## Verification
A broken slot register or decision step shows at once on trial_code. The code is wrong within 8 clocks of the bad slot, and result differs when irq_n falls 64 clocks after launch. A fault in the start flip-flop or the time base shows as a launch delay outside 1 to 8 clocks, as a missing delay value across eight phase offsets, or as a free-running period other than 72 clocks. A latch or interrupt fault shows as result moving while irq_n is high, or as irq_n rising without a start.

// File: rtl/sarctl_pkg.sv
package sarctl_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned SLOT_CLKS = 8;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/sarctl_rst_sync.sv
module sarctl_rst_sync #(
  parameter int unsigned STAGES = sarctl_pkg::SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/sarctl_start.sv
module sarctl_start #(
  parameter int unsigned SLOT_CLKS = sarctl_pkg::SLOT_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic start_req,
  output logic launch,
  output logic tick
);
  localparam int unsigned    PH_W    = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            hold_q, hold_d, hold_en;

  // start condition: both strobes low together
  assign start_req = ~cs_n & ~wr_n;
  // last clock of the free-running slot time base
  assign tick      = (phase_q == PH_LAST);
  // clock-qualified release: only when the strobes are gone
  assign launch    = hold_q & tick & ~start_req;

  always_comb begin
    phase_d = tick ? '0 : phase_q + 1'b1;
    hold_en = start_req | launch;
    hold_d  = start_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (hold_en) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/sarctl_sar.sv
module sarctl_sar #(
  parameter int unsigned CODE_W = sarctl_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              launch,
  input  logic              tick,
  input  logic              cmp_lo,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] result,
  output logic              irq_n,
  output logic [CODE_W-1:0] slot_vec
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] slot_q, slot_d;
  logic [CODE_W-1:0] trial_q, trial_d;
  logic [CODE_W-1:0] res_q;
  logic [CODE_W-1:0] decided;
  logic              irq_q, irq_d;
  logic              busy, step, seq_en, res_en, irq_en;

  assign busy = |slot_q;
  assign step = tick & busy;

  // per-bit decision: clear the bit under test when input is below trial
  generate
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      assign decided[i] = trial_q[i] & ~(slot_q[i] & cmp_lo);
    end
  endgenerate

  always_comb begin
    slot_d  = slot_q;
    trial_d = trial_q;
    irq_d   = irq_q;
    seq_en  = start_req | launch | step;
    res_en  = 1'b0;
    irq_en  = 1'b0;
    if (start_req) begin
      slot_d  = '0;
      trial_d = '0;
      irq_d   = 1'b1;
      irq_en  = 1'b1;
    end else if (launch) begin
      slot_d  = MSB_ONLY;
      trial_d = MSB_ONLY;
    end else if (step) begin
      slot_d  = slot_q >> 1;
      trial_d = decided | (slot_q >> 1);
      if (slot_q[0]) begin
        res_en = 1'b1;
        irq_d  = 1'b0;
        irq_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      trial_q <= '0;
      res_q   <= '0;
      irq_q   <= 1'b1;
    end else begin
      if (seq_en) begin
        slot_q  <= slot_d;
        trial_q <= trial_d;
      end
      if (res_en) res_q <= decided;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign trial_code = trial_q;
  assign result     = res_q;
  assign irq_n      = irq_q;
  assign slot_vec   = slot_q;
endmodule

// File: rtl/sarctl_top.sv
module sarctl_top #(
  parameter int unsigned CODE_W    = sarctl_pkg::CODE_W,
  parameter int unsigned SLOT_CLKS = sarctl_pkg::SLOT_CLKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              cmp_lo,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] result,
  output logic              irq_n
);
  logic              rst_sn;
  logic              start_req, launch, tick;
  logic [CODE_W-1:0] slot_vec;

  sarctl_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sarctl_start #(.SLOT_CLKS(SLOT_CLKS)) u_start (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .start_req (start_req),
    .launch    (launch),
    .tick      (tick)
  );

  sarctl_sar #(.CODE_W(CODE_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_req  (start_req),
    .launch     (launch),
    .tick       (tick),
    .cmp_lo     (cmp_lo),
    .trial_code (trial_code),
    .result     (result),
    .irq_n      (irq_n),
    .slot_vec   (slot_vec)
  );
endmodule

// File: rtl/sarctl_chk.sv
module sarctl_chk #(
  parameter int unsigned CODE_W = sarctl_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic [CODE_W-1:0] trial_code,
  input logic [CODE_W-1:0] result,
  input logic              irq_n,
  input logic [CODE_W-1:0] slot_vec
);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_n && !wr_n) |-> (trial_code == '0 && irq_n));

  // R8
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(!cs_n && !wr_n)) |=> !irq_n);

  // R8
  result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(irq_n) |-> $stable(result));

  // R5
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_vec));

  // R5
  trial_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_vec != '0) && $stable(slot_vec)) |-> $stable(trial_code));

  // R6
  irq_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(slot_vec[0]));
endmodule

bind sarctl_top sarctl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .trial_code (trial_code),
  .result     (result),
  .irq_n      (irq_n),
  .slot_vec   (slot_vec)
);

// File: tb/sarctl_top_bench.sv
module sarctl_top_bench;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, wr_drv, fr_mode, wr_n, cmp_lo, irq_n;
  logic [7:0] vin, trial_code, result;
  int         nchk = 0;
  int         nfail = 0;

  always #4 clk = ~clk;

  assign wr_n   = fr_mode ? irq_n : wr_drv;
  assign cmp_lo = (vin < trial_code);

  sarctl_top u_sarctl_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .cmp_lo(cmp_lo),
    .trial_code(trial_code), .result(result), .irq_n(irq_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    @(negedge clk);
    chk("R2", "irq_n after start", int'(irq_n), 1);
    chk("R2", "trial after start", int'(trial_code), 0);
    wr_drv = 1'b1;
  endtask

  task automatic wait_launch(output int d);
    d = 0;
    do begin
      @(negedge clk); d++;
    end while (trial_code == 8'h00 && d < 40);
  endtask

  task automatic body(input int v, input int prev);
    for (int t = 0; t < 64; t++) begin
      int b;
      int e;
      b = 7 - t / 8;
      e = (v & ~((1 << (b + 1)) - 1) & 255) | (1 << b);
      if (t % 8 == 0 || t % 8 == 7) chk("R5", "trial in slot", int'(trial_code), e);
      chk("R8", "result held", int'(result), prev);
      chk("R6", "irq_n while busy", int'(irq_n), 1);
      @(negedge clk);
    end
    chk("R6", "irq_n at clock 64", int'(irq_n), 0);
    chk("R7", "result code", int'(result), v);
  endtask

  task automatic convert(input int v, output int d);
    int prev;
    prev = int'(result);
    vin = v[7:0];
    strobe();
    wait_launch(d);
    chk("R4", "launch delay within 1..8", int'(d >= 1 && d <= 8), 1);
    body(v, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int d;
    int mask;
    int cnt;
    rst_n = 1'b0; cs_n = 1'b1; wr_drv = 1'b1; fr_mode = 1'b0; vin = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (24) @(negedge clk);
    chk("R1", "irq_n idle", int'(irq_n), 1);
    chk("R1", "trial idle", int'(trial_code), 0);
    chk("R1", "result idle", int'(result), 0);

    // R2: wide strobe keeps the sequencer cleared
    cs_n = 1'b0; wr_drv = 1'b0; vin = 8'h33;
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R2", "trial held clear", int'(trial_code), 0);
      chk("R2", "irq_n held high", int'(irq_n), 1);
    end
    wr_drv = 1'b1;
    wait_launch(d);
    chk("R4", "delay after wide strobe", int'(d >= 1 && d <= 8), 1);
    body(8'h33, 0);

    // R5 R6 R7: single conversions
    convert(8'h00, d);
    convert(8'hFF, d);
    convert(8'hA5, d);
    convert(8'h5A, d);
    convert(8'h01, d);
    convert(8'h80, d);
    convert(8'h7F, d);

    // R4: eight phase offsets give each delay once
    mask = 0;
    for (int j = 0; j < 8; j++) begin
      repeat (j) @(negedge clk);
      convert(8'h40 + j, d);
      if (d >= 1 && d <= 8) mask |= (1 << (d - 1));
    end
    chk("R4", "delay set 1..8", mask, 255);

    // R3: write without select is ignored
    cs_n = 1'b1; wr_drv = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3", "irq_n unchanged", int'(irq_n), 0);
    chk("R3", "trial unchanged", int'(trial_code), 8'h47);
    chk("R3", "result unchanged", int'(result), 8'h47);
    wr_drv = 1'b1; cs_n = 1'b0;

    // R8: interrupt stays low while idle
    repeat (30) @(negedge clk);
    chk("R8", "irq_n stays low", int'(irq_n), 0);

    // R9: restart mid-conversion
    vin = 8'h5A;
    strobe();
    wait_launch(d);
    repeat (20) @(negedge clk);
    vin = 8'hC3;
    strobe();
    chk("R9", "result kept on abort", int'(result), 8'h47);
    wait_launch(d);
    chk("R9", "relaunch delay within 1..8", int'(d >= 1 && d <= 8), 1);
    body(8'hC3, 8'h47);
    chk("R9", "restarted result", int'(result), 8'hC3);

    // R10: free-running loop
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0; vin = 8'h00; fr_mode = 1'b1;
    repeat (100) @(negedge clk);
    chk("R10", "no start without pulse", int'(trial_code), 0);
    chk("R10", "irq_n high without pulse", int'(irq_n), 1);
    fr_mode = 1'b0; wr_drv = 1'b0;
    @(negedge clk);
    wr_drv = 1'b1; fr_mode = 1'b1;
    for (int i = 0; i < 256; i++) begin
      cnt = (i == 0) ? 0 : 1;
      do begin
        @(negedge clk); cnt++;
      end while (irq_n && cnt < 300);
      chk("R7", "free-run result", int'(result), i);
      if (i > 0) chk("R10", "free-run period", cnt, 72);
      vin = 8'(i + 1);
      @(negedge clk);
      chk("R10", "irq_n low one clock", int'(irq_n), 1);
    end
    fr_mode = 1'b0; wr_drv = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule